// File: doc/BRIEF.md
# Per-Core Interrupt Mask and Pending CSRs

This block takes a vector of level-sensitive interrupt lines from devices and presents them to several processor cores at once. Each core owns a private mask register and a private, read-only view of the incoming lines. Both sit in a small window of CSR addresses starting at 0x7C0, interleaved per core. A core's irq output is high whenever any line is both active and unmasked for that core.

The device lines may be asynchronous to the block's clock. They first pass through a two-flop synchronizer, and every core sees the same synchronized copy. The block never latches or clears an interrupt. A line stays visible, and keeps irq high, until the device itself drops it. Software handles the cause at the device.

Each core talks to the block over its own CSR port. The port carries an address, write data, a write strobe and combinational read data. These are plain control pins with no handshake: a write takes effect at the clock edge on which the strobe is high, and read data follows the address within the same cycle. Up to 8 cores are supported.

Top module: `irq_fanout_csr`

## Requirements
- R1: After reset every core's mask register reads 0 and every irq output is low, whatever the device lines do.
- R2: Core i's mask register is at address 0x7C0 + 2*i and its pending register is at 0x7C1 + 2*i, both reached through core i's own port. A pending read returns the synchronized device lines in bits [N_SRC-1:0].
- R3: A write to a core's pending address changes nothing: its mask and its pending read-back keep their values.
- R4: A core's irq is the OR over all sources of (synchronized line AND that core's mask bit). Each core uses only its own mask.
- R5: Mask bit k gates source k alone. For example, mask 0x9 lets only sources 0 and 3 raise the irq.
- R6: Interrupts are levels. irq stays high for as long as an unmasked line is held, and falls only after the device drops the line.
- R7: A change on a device line is visible in the pending read two clock edges later and on irq three clock edges later.
- R8: A port ignores every address outside its own core's pair. Such reads return 0 and such writes change no register, including the registers of other cores.
- R9: Read-data bits at or above N_SRC are always 0, and written values in those bits are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_i | input | N_SRC | Raw level interrupt lines from devices |
| csr_addr_i | input | N_CORES*12 | CSR address per core, core i in slice i |
| csr_wdata_i | input | N_CORES*32 | CSR write data per core |
| csr_we_i | input | N_CORES | CSR write strobe per core |
| csr_rdata_o | output | N_CORES*32 | CSR read data per core, combinational |
| irq_o | output | N_CORES | Interrupt request per core, registered |

## Verification
The bench builds the block with the full 8 cores and 5 sources. With 8 cores the last pair sits at 0x7CE/0x7CF, so the bench can show that the next address, 0x7D0, and the address just below the window are both ignored. With 5 sources, 27 read-data bits must read as zero, yet source 3 still exists, so the 0x9 mask example can be checked. Each test routine queues the values the ports should show, and a monitor compares them. This covers the exact synchronizer and irq latencies, writes that land on other cores' addresses, and long held levels.

// File: rtl/irqfan_pkg.sv
package irqfan_pkg;
  localparam int unsigned CSR_AW    = 12;
  localparam int unsigned CSR_DW    = 32;
  localparam int unsigned MAX_CORES = 8;
  localparam logic [CSR_AW-1:0] WIN_BASE = 12'h7C0;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_MASK,
    SEL_PEND
  } slot_sel_e;

  // Mask register of a core: even slot of its pair.
  function automatic logic [CSR_AW-1:0] mask_addr(input int unsigned core);
    return WIN_BASE + CSR_AW'(2 * core);
  endfunction

  // Pending view of a core: odd slot of its pair.
  function automatic logic [CSR_AW-1:0] pend_addr(input int unsigned core);
    return WIN_BASE + CSR_AW'(2 * core + 1);
  endfunction
endpackage

// File: rtl/irqfan_sync.sv
module irqfan_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q[0] <= '0;
    else         stage_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else         stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/irqfan_decode.sv
module irqfan_decode
  import irqfan_pkg::*;
#(
  parameter int unsigned CORE_ID = 0
) (
  input  logic [CSR_AW-1:0] addr_i,
  output slot_sel_e         sel_o
);
  localparam logic [CSR_AW-1:0] MaskA = mask_addr(CORE_ID);
  localparam logic [CSR_AW-1:0] PendA = pend_addr(CORE_ID);

  always_comb begin
    sel_o = SEL_NONE;
    if (addr_i == MaskA)      sel_o = SEL_MASK;
    else if (addr_i == PendA) sel_o = SEL_PEND;
  end
endmodule

// File: rtl/irqfan_slot.sv
module irqfan_slot
  import irqfan_pkg::*;
#(
  parameter int unsigned N_SRC   = 8,
  parameter int unsigned CORE_ID = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  src_sync_i,
  input  logic [CSR_AW-1:0] addr_i,
  input  logic [CSR_DW-1:0] wdata_i,
  input  logic              we_i,
  output logic [CSR_DW-1:0] rdata_o,
  output logic              irq_o
);
  slot_sel_e        sel;
  logic [N_SRC-1:0] mask_q;
  logic             irq_q;

  irqfan_decode #(.CORE_ID(CORE_ID)) u_dec (
    .addr_i (addr_i),
    .sel_o  (sel)
  );

  // Only the mask slot is writable; the pending slot drops writes.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     mask_q <= '0;
    else if (we_i && sel == SEL_MASK) mask_q <= wdata_i[N_SRC-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(src_sync_i & mask_q);
  end

  always_comb begin
    unique case (sel)
      SEL_MASK: rdata_o = CSR_DW'(mask_q);
      SEL_PEND: rdata_o = CSR_DW'(src_sync_i);
      default:  rdata_o = '0;
    endcase
  end

  assign irq_o = irq_q;

  if (N_SRC < CSR_DW) begin : g_hi
    logic unused_wdata_hi;
    assign unused_wdata_hi = ^wdata_i[CSR_DW-1:N_SRC];
  end
endmodule

// File: rtl/irq_fanout_csr.sv
module irq_fanout_csr
  import irqfan_pkg::*;
#(
  parameter int unsigned N_CORES = 4,
  parameter int unsigned N_SRC   = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [N_SRC-1:0]          src_i,
  input  logic [N_CORES*CSR_AW-1:0] csr_addr_i,
  input  logic [N_CORES*CSR_DW-1:0] csr_wdata_i,
  input  logic [N_CORES-1:0]        csr_we_i,
  output logic [N_CORES*CSR_DW-1:0] csr_rdata_o,
  output logic [N_CORES-1:0]        irq_o
);
  localparam int unsigned SyncStages = 2;

  logic [N_SRC-1:0] src_sync;

  irqfan_sync #(.WIDTH(N_SRC), .STAGES(SyncStages)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (src_i),
    .q_o    (src_sync)
  );

  for (genvar c = 0; c < N_CORES; c++) begin : g_core
    irqfan_slot #(.N_SRC(N_SRC), .CORE_ID(c)) u_slot (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .src_sync_i (src_sync),
      .addr_i     (csr_addr_i[c*CSR_AW +: CSR_AW]),
      .wdata_i    (csr_wdata_i[c*CSR_DW +: CSR_DW]),
      .we_i       (csr_we_i[c]),
      .rdata_o    (csr_rdata_o[c*CSR_DW +: CSR_DW]),
      .irq_o      (irq_o[c])
    );
  end
endmodule

// File: rtl/irqfan_slot_chk.sv
module irqfan_slot_chk
  import irqfan_pkg::*;
#(
  parameter int unsigned N_SRC   = 8,
  parameter int unsigned CORE_ID = 0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [N_SRC-1:0]  src_sync_i,
  input logic [N_SRC-1:0]  mask_q,
  input logic [CSR_AW-1:0] addr_i,
  input logic              we_i,
  input logic [CSR_DW-1:0] rdata_o,
  input logic              irq_o
);
  localparam logic [CSR_AW-1:0] MaskA = mask_addr(CORE_ID);
  localparam logic [CSR_AW-1:0] PendA = pend_addr(CORE_ID);

  assert_irq_follow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == |($past(src_sync_i) & $past(mask_q)))
    else $error("irq does not follow masked lines");

  assert_masked_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q == '0) |=> !irq_o)
    else $error("irq raised with empty mask");

  assert_mask_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && addr_i == MaskA) |=> $stable(mask_q))
    else $error("mask changed without own write");

  assert_pend_write_ro_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == PendA) |=> $stable(mask_q))
    else $error("pending write disturbed mask");

  assert_pend_read_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == PendA) |-> (rdata_o == CSR_DW'(src_sync_i)))
    else $error("pending read mismatch");

  always_ff @(posedge clk_i) begin
    if (rst_ni && addr_i != MaskA && addr_i != PendA)
      assert_outside_zero_R8: assert (rdata_o == '0)
        else $error("foreign address read nonzero");
  end

  if (N_SRC < CSR_DW) begin : g_hi
    always_ff @(posedge clk_i) begin
      if (rst_ni)
        assert_hi_zero_R9: assert (rdata_o[CSR_DW-1:N_SRC] == '0)
          else $error("high read bits nonzero");
    end
  end
endmodule

bind irqfan_slot irqfan_slot_chk #(.N_SRC(N_SRC), .CORE_ID(CORE_ID)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .src_sync_i (src_sync_i),
  .mask_q     (mask_q),
  .addr_i     (addr_i),
  .we_i       (we_i),
  .rdata_o    (rdata_o),
  .irq_o      (irq_o)
);

// File: tb/sim_irq_fanout_csr.sv
module sim_irq_fanout_csr;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 8;
  localparam int NS = 5;
  localparam int AW = 12;
  localparam int DW = 32;
  localparam logic [31:0] SMASK = 32'h1F;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NS-1:0]  src = '0;
  logic [NC*AW-1:0] addr = '0;
  logic [NC*DW-1:0] wdata = '0;
  logic [NC-1:0]  we = '0;
  logic [NC*DW-1:0] rdata;
  logic [NC-1:0]  irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    bit          is_irq;
    int          core;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb[$];
  event mon_ev;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_fanout_csr #(.N_CORES(NC), .N_SRC(NS)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src),
    .csr_addr_i(addr), .csr_wdata_i(wdata), .csr_we_i(we),
    .csr_rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic [AW-1:0] ma(int c); return 12'h7C0 + AW'(2*c); endfunction
  function automatic logic [AW-1:0] pa(int c); return 12'h7C1 + AW'(2*c); endfunction

  // Monitor: pops expected items and compares against the ports.
  initial begin
    forever begin
      @(mon_ev);
      while (sb.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = sb.pop_front();
        act = it.is_irq ? 32'(irq) : rdata[it.core*DW +: DW];
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s core=%0d irq=%0d actual=%h expected=%h",
                   it.tag, it.core, it.is_irq, act, it.exp);
        end
      end
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic exp_rd(int c, logic [AW-1:0] a, logic [31:0] e, string tag);
    item_t it;
    addr[c*AW +: AW] = a;
    we[c] = 1'b0;
    #1;
    it.is_irq = 0; it.core = c; it.exp = e; it.tag = tag;
    sb.push_back(it);
    -> mon_ev;
    #1;
  endtask

  task automatic exp_irq(logic [NC-1:0] e, string tag);
    item_t it;
    #1;
    it.is_irq = 1; it.core = 0; it.exp = 32'(e); it.tag = tag;
    sb.push_back(it);
    -> mon_ev;
    #1;
  endtask

  // Drives a write just after a falling edge; it lands on the next rising edge.
  task automatic csr_wr(int c, logic [AW-1:0] a, logic [31:0] d);
    addr[c*AW +: AW]  = a;
    wdata[c*DW +: DW] = d;
    we[c] = 1'b1;
    @(negedge clk);
    we[c] = 1'b0;
  endtask

  task automatic summary;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  logic [31:0] mval [NC];

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    // R1: reset state
    for (int c = 0; c < NC; c++) exp_rd(c, ma(c), 32'h0, "R1");
    exp_irq('0, "R1");
    src = 5'h1F;
    step(5);
    exp_irq('0, "R1");

    // R2: per-core map
    for (int c = 0; c < NC; c++) begin
      mval[c] = ((c * 3 + 1) & SMASK);
      csr_wr(c, ma(c), mval[c]);
    end
    for (int c = 0; c < NC; c++) exp_rd(c, ma(c), mval[c], "R2");
    for (int c = 0; c < NC; c++) exp_rd(c, pa(c), 32'h1F, "R2");
    step(2);
    exp_irq('1, "R4");

    // R8: foreign addresses
    exp_rd(0, ma(1), 32'h0, "R8");
    exp_rd(3, 12'h7BF, 32'h0, "R8");
    exp_rd(3, 12'h7D0, 32'h0, "R8");
    exp_rd(7, pa(6), 32'h0, "R8");
    csr_wr(2, ma(5), 32'h0);
    csr_wr(2, 12'h7D0, 32'h0);
    step(1);
    exp_rd(5, ma(5), mval[5], "R8");
    exp_rd(2, ma(2), mval[2], "R8");

    // R3: pending is read-only
    csr_wr(4, pa(4), 32'h0);
    step(1);
    exp_rd(4, ma(4), mval[4], "R3");
    exp_rd(4, pa(4), 32'h1F, "R3");

    // R9: high bits
    csr_wr(6, ma(6), 32'hFFFF_FFFF);
    step(1);
    exp_rd(6, ma(6), 32'h1F, "R9");
    exp_rd(6, pa(6), 32'h1F, "R9");

    // R5: mask 0x9 on core 0, others cleared
    csr_wr(0, ma(0), 32'h9);
    for (int c = 1; c < NC; c++) csr_wr(c, ma(c), 32'h0);
    src = 5'h02; step(4);
    exp_irq('0, "R5");
    src = 5'h08; step(4);
    exp_irq(8'h01, "R5");
    src = 5'h01; step(4);
    exp_irq(8'h01, "R5");
    src = 5'h16; step(4);
    exp_irq('0, "R5");

    // R4: independent masks
    csr_wr(1, ma(1), 32'h06);
    csr_wr(2, ma(2), 32'h10);
    src = 5'h04; step(4);
    exp_irq(8'h02, "R4");
    src = 5'h10; step(4);
    exp_irq(8'h04, "R4");
    src = 5'h19; step(4);
    exp_irq(8'h05, "R4");

    // R7: latency on a falling line
    src = 5'h00;
    step(1);
    exp_rd(0, pa(0), 32'h19, "R7");
    exp_irq(8'h05, "R7");
    step(1);
    exp_rd(0, pa(0), 32'h00, "R7");
    exp_irq(8'h05, "R7");
    step(1);
    exp_irq('0, "R7");
    // R7: latency on a rising line
    src = 5'h08;
    step(2);
    exp_rd(0, pa(0), 32'h08, "R7");
    exp_irq('0, "R7");
    step(1);
    exp_irq(8'h01, "R7");

    // R6: level held, no self-clearing
    for (int k = 0; k < 4; k++) begin
      step(5);
      exp_irq(8'h01, "R6");
    end
    src = 5'h00;
    step(3);
    exp_irq('0, "R6");

    step(2);
    done = 1;
    summary();
    $finish;
  end
endmodule